// File: doc/BRIEF.md
# I2C Dynamic Command Sequencer

This block sits between a command queue and a bit-level I2C master engine. Software, or a filling agent, places 10-bit command entries into the queue. Each entry holds one byte in bits 7:0, a start request in bit 8 and a stop request in bit 9. The sequencer decodes the stream and hands the engine one operation at a time: start, write byte, read byte or stop. Bytes received on a read leave through a receive stream. Start conditions, stop conditions and read lengths all travel inside the data stream, so there is no control register to program between messages.

A start entry carries the address byte, and bit 0 of that byte selects a read (1) or a write (0). After a write address, plain entries are data bytes. After a read address, the next entry is a byte count from 0 to 255. The stop flag on the last data entry, or on the count entry, closes the transfer. If no stop flag is given, the bus stays held and the next start entry becomes a repeated start. Three one-cycle event pulses report what happens on the bus: a transmit error, a lost arbitration, and the bus returning to idle after a stop.

The command input and the receive output are valid/ready streams. A command entry moves when `cmd_valid` and `cmd_ready` are both high at a clock edge. The sequencer raises `cmd_ready` only while no operation is outstanding and no received byte is waiting, so an empty queue simply stalls it. A received byte stays on `rx_data`, with `rx_valid` held high, until `rx_ready` is seen. While it waits, no further read is issued. An engine operation moves when `op_valid` and `op_ready` are both high. Its fields stay stable until then. The engine answers later with a one-cycle `op_done`.

Top module: `i2c_dyn_sequencer`

## Requirements
- R1: An entry with bit 8 set, taken while idle or after write data, is issued as operation kind 0 (start) followed by kind 1 (write) carrying bits 7:0 as the address byte. Plain entries after a write address are issued as kind 1 writes of their bits 7:0.
- R2: After an acknowledged address with bit 0 = 1, the next entry's bits 7:0 give N. Exactly N kind 2 (read) operations follow, and each received byte appears on the receive stream in the order it was read.
- R3: Every read operation has `op_ack` = 1 except the last of a message, which has `op_ack` = 0. `op_ack` is 0 for every other kind.
- R4: A stop flag (bit 9) on a write data entry or on a count entry issues a kind 3 (stop) after that byte. Once the stop completes and `bus_busy` is low, `ev_bus_idle` pulses for one cycle.
- R5: Without a stop flag the bus stays held. The next entry with bit 8 set is issued as a start with no stop before it.
- R6: A single entry with both bit 8 and bit 9 set and address bit 0 = 0 produces start, address write, stop.
- R7: A NACK on an address or data write pulses `ev_tx_error`, issues a stop, and discards the remaining entries of the message that lack bit 8.
- R8: Completion of the last read byte of a message pulses `ev_tx_error`.
- R9: A lost arbitration on any operation pulses `ev_arb_lost`. No stop is issued, and later entries without bit 8 are discarded.
- R10: Entries without bit 8 that arrive while no transfer is held, or while the bus is held after a read, are consumed and produce no operation.
- R11: `cmd_ready` is high only while no engine operation is pending or outstanding and no received byte awaits `rx_ready`.
- R12: `op_valid` with its fields, and `rx_valid` with `rx_data`, stay stable until accepted.
- R13: A count of 0 produces no read operation and no `ev_tx_error`. Its stop flag still produces a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command entry available |
| cmd_ready | output | 1 | Sequencer takes the entry |
| cmd_data | input | 10 | Entry: bit 9 stop, bit 8 start, bits 7:0 byte |
| op_valid | output | 1 | Engine operation request |
| op_ready | input | 1 | Engine accepts the request |
| op_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| op_byte | output | 8 | Byte for write operations, else 0 |
| op_ack | output | 1 | Read: 1 acknowledge, 0 NACK |
| op_done | input | 1 | Engine finished the outstanding operation |
| op_nack | input | 1 | With op_done: write was not acknowledged |
| op_arb_lost | input | 1 | With op_done: arbitration lost |
| op_rdata | input | 8 | With op_done: received byte |
| bus_busy | input | 1 | Bus currently held between start and stop |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| ev_tx_error | output | 1 | Pulse: write NACK or last read byte |
| ev_arb_lost | output | 1 | Pulse: arbitration lost |
| ev_bus_idle | output | 1 | Pulse: bus idle after a stop |

## Verification
The bench targets these corner cases:
- A repeated start after both a held write and a held read. A design that lost track of the held bus would slip in a stop or drop the start.
- A zero-length read. Getting it wrong shows up as a spurious read or transmit-error pulse.
- A 255-byte read under receive back-pressure. A narrow or miscounted length shows up as a short transfer or a wrongly acknowledged last byte.
- An address NACK, a data NACK and an arbitration loss, each followed by trailing data entries. A sequencer that failed to discard them would write stray bytes, and one that issued a stop after lost arbitration would show an extra operation.
- Stray entries while idle, and gaps in the command stream. These expose premature fetching and entries that are not dropped.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {
    OPK_START = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_READ  = 2'd2,
    OPK_STOP  = 2'd3
  } opk_t;

  typedef enum logic [1:0] {
    CTX_FREE,
    CTX_WR,
    CTX_RDLEN,
    CTX_HOLD
  } ctx_t;

  typedef enum logic [1:0] {
    ACT_DROP,
    ACT_START,
    ACT_WRITE,
    ACT_COUNT
  } act_t;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_START,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_PUSH,
    ST_STOP,
    ST_IDLEWAIT
  } st_t;

  localparam int EV_TXERR = 0;
  localparam int EV_ARB   = 1;
  localparam int EV_IDLE  = 2;
  localparam int EV_N     = 3;
endpackage

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
  import i2cseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CMD_W = BYTE_W + 2
) (
  input  logic [CMD_W-1:0]  entry,
  input  ctx_t              ctx,
  output logic [BYTE_W-1:0] byte_o,
  output logic              start_o,
  output logic              stop_o,
  output act_t              act
);
  assign byte_o  = entry[BYTE_W-1:0];
  assign start_o = entry[BYTE_W];
  assign stop_o  = entry[BYTE_W+1];

  always_comb begin
    unique case (ctx)
      CTX_WR:    act = start_o ? ACT_START : ACT_WRITE;
      CTX_RDLEN: act = ACT_COUNT;
      default:   act = start_o ? ACT_START : ACT_DROP;
    endcase
  end
endmodule

// File: rtl/i2cseq_counter.sv
module i2cseq_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/i2cseq_events.sv
module i2cseq_events #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] pulse
);
  for (genvar g = 0; g < N; g++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= set[g];
    end
  end
endmodule

// File: rtl/i2c_dyn_sequencer.sv
module i2c_dyn_sequencer
  import i2cseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CMD_W = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [1:0]        op_kind,
  output logic [BYTE_W-1:0] op_byte,
  output logic              op_ack,
  input  logic              op_done,
  input  logic              op_nack,
  input  logic              op_arb_lost,
  input  logic [BYTE_W-1:0] op_rdata,
  input  logic              bus_busy,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ev_tx_error,
  output logic              ev_arb_lost,
  output logic              ev_bus_idle
);
  st_t  st_q, st_d;
  ctx_t ctx_q, ctx_d;
  logic [BYTE_W-1:0] ent_byte_q, rx_q, rx_d;
  logic ent_stop_q, issued_q, issued_d, latch;
  logic cnt_load, cnt_dec, cnt_last, done;
  logic [EV_N-1:0] ev_set, ev_pulse;

  logic [BYTE_W-1:0] dec_byte;
  logic dec_start, dec_stop;
  act_t dec_act;

  i2cseq_decode #(.BYTE_W(BYTE_W)) u_dec (
    .entry(cmd_data), .ctx(ctx_q), .byte_o(dec_byte),
    .start_o(dec_start), .stop_o(dec_stop), .act(dec_act)
  );

  i2cseq_counter #(.CNT_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(dec_byte),
    .dec(cnt_dec), .last(cnt_last)
  );

  i2cseq_events #(.N(EV_N)) u_ev (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .pulse(ev_pulse)
  );

  assign ev_tx_error = ev_pulse[EV_TXERR];
  assign ev_arb_lost = ev_pulse[EV_ARB];
  assign ev_bus_idle = ev_pulse[EV_IDLE];

  // engine request side
  always_comb begin
    op_valid = 1'b0;
    op_kind  = OPK_START;
    op_byte  = '0;
    op_ack   = 1'b0;
    unique case (st_q)
      ST_START: begin op_valid = !issued_q; op_kind = OPK_START; end
      ST_ADDR, ST_WRITE: begin
        op_valid = !issued_q;
        op_kind  = OPK_WRITE;
        op_byte  = ent_byte_q;
      end
      ST_READ: begin
        op_valid = !issued_q;
        op_kind  = OPK_READ;
        op_ack   = !cnt_last;
      end
      ST_STOP: begin op_valid = !issued_q; op_kind = OPK_STOP; end
      default: ;
    endcase
  end

  assign done      = issued_q && op_done;
  assign cmd_ready = (st_q == ST_FETCH);
  assign rx_valid  = (st_q == ST_PUSH);
  assign rx_data   = rx_q;

  always_comb begin
    st_d     = st_q;
    ctx_d    = ctx_q;
    rx_d     = rx_q;
    latch    = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    ev_set   = '0;
    issued_d = issued_q;
    if (op_valid && op_ready) issued_d = 1'b1;
    if (done)                 issued_d = 1'b0;

    unique case (st_q)
      ST_FETCH: if (cmd_valid) begin
        latch = 1'b1;
        unique case (dec_act)
          ACT_START: st_d = ST_START;
          ACT_WRITE: st_d = ST_WRITE;
          ACT_COUNT: begin
            cnt_load = 1'b1;
            if (dec_byte != '0)  st_d  = ST_READ;
            else if (dec_stop)   st_d  = ST_STOP;
            else                 ctx_d = CTX_HOLD;
          end
          default: ;
        endcase
      end
      ST_START: if (done) begin
        if (op_arb_lost) begin
          ev_set[EV_ARB] = 1'b1; ctx_d = CTX_FREE; st_d = ST_FETCH;
        end else st_d = ST_ADDR;
      end
      ST_ADDR, ST_WRITE: if (done) begin
        if (op_arb_lost) begin
          ev_set[EV_ARB] = 1'b1; ctx_d = CTX_FREE; st_d = ST_FETCH;
        end else if (op_nack) begin
          ev_set[EV_TXERR] = 1'b1; st_d = ST_STOP;
        end else if (st_q == ST_ADDR && ent_byte_q[0]) begin
          ctx_d = CTX_RDLEN; st_d = ST_FETCH;
        end else if (ent_stop_q) begin
          st_d = ST_STOP;
        end else begin
          ctx_d = CTX_WR; st_d = ST_FETCH;
        end
      end
      ST_READ: if (done) begin
        if (op_arb_lost) begin
          ev_set[EV_ARB] = 1'b1; ctx_d = CTX_FREE; st_d = ST_FETCH;
        end else begin
          rx_d = op_rdata; st_d = ST_PUSH;
        end
      end
      ST_PUSH: if (rx_ready) begin
        cnt_dec = 1'b1;
        if (cnt_last) begin
          ev_set[EV_TXERR] = 1'b1;
          if (ent_stop_q) st_d = ST_STOP;
          else begin ctx_d = CTX_HOLD; st_d = ST_FETCH; end
        end else st_d = ST_READ;
      end
      ST_STOP: if (done) begin
        ctx_d = CTX_FREE; st_d = ST_IDLEWAIT;
      end
      ST_IDLEWAIT: if (!bus_busy) begin
        ev_set[EV_IDLE] = 1'b1; st_d = ST_FETCH;
      end
      default: st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_FETCH;
      ctx_q      <= CTX_FREE;
      ent_byte_q <= '0;
      ent_stop_q <= 1'b0;
      issued_q   <= 1'b0;
      rx_q       <= '0;
    end else begin
      st_q     <= st_d;
      ctx_q    <= ctx_d;
      issued_q <= issued_d;
      rx_q     <= rx_d;
      if (latch) begin
        ent_byte_q <= dec_byte;
        ent_stop_q <= dec_stop;
      end
    end
  end
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_kind,
  input logic [BYTE_W-1:0] op_byte,
  input logic              op_ack,
  input logic              bus_busy,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] rx_data,
  input logic              ev_tx_error,
  input logic              ev_arb_lost,
  input logic              ev_bus_idle
);
  p_op_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_byte) && $stable(op_ack));

  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_fetch_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !op_valid && !rx_valid);

  p_ack_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind != 2'd2 |-> !op_ack);

  p_event_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_tx_error, ev_arb_lost, ev_bus_idle}));

  p_idle_after_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_idle |-> $past(bus_busy) == 1'b0);

  p_no_op_after_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |-> !op_valid);
endmodule

bind i2c_dyn_sequencer i2cseq_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .op_valid(op_valid),
  .op_ready(op_ready), .op_kind(op_kind), .op_byte(op_byte), .op_ack(op_ack),
  .bus_busy(bus_busy), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .ev_tx_error(ev_tx_error), .ev_arb_lost(ev_arb_lost),
  .ev_bus_idle(ev_bus_idle)
);

// File: tb/i2c_dyn_sequencer_tb_top.sv
module i2c_dyn_sequencer_tb_top;
  localparam int BW = 8;
  localparam int CW = BW + 2;
  localparam logic [7:0] NACK_BYTE = 8'hEE;
  localparam logic [7:0] ARB_BYTE  = 8'hC3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, op_valid, op_ready, op_ack;
  logic op_done, op_nack, op_arb_lost, bus_busy, rx_valid, rx_ready;
  logic ev_tx_error, ev_arb_lost, ev_bus_idle;
  logic [CW-1:0] cmd_data;
  logic [1:0] op_kind;
  logic [BW-1:0] op_byte, op_rdata, rx_data;

  i2c_dyn_sequencer #(.BYTE_W(BW)) dut_i (.*);

  int checks = 0, fails = 0;
  logic [CW-1:0] cmd_q[$];
  int exp_ops[$];   string op_tag[$];
  int exp_rx[$];
  int exp_ev[$];    string ev_tag[$];
  int m_ctx;        // 0 free, 1 write, 2 read length, 3 held after read
  logic [7:0] m_rd;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int enc(int kind, int ack, int b);
    return kind * 512 + ack * 256 + b;
  endfunction

  task automatic m_op(int kind, int ack, int b, string tag);
    exp_ops.push_back(enc(kind, ack, b)); op_tag.push_back(tag);
  endtask

  task automatic m_ev(int code, string tag);
    exp_ev.push_back(code); ev_tag.push_back(tag);
  endtask

  task automatic m_write_result(logic [7:0] b, bit sp, bit is_addr);
    if (b == ARB_BYTE) begin
      m_ev(2, "R9"); m_ctx = 0;
    end else if (b == NACK_BYTE) begin
      m_ev(1, "R7"); m_op(3, 0, 0, "R7"); m_ev(3, "R4"); m_ctx = 0;
    end else if (is_addr && b[0]) begin
      m_ctx = 2;
    end else if (sp) begin
      m_op(3, 0, 0, is_addr ? "R6" : "R4"); m_ev(3, "R4"); m_ctx = 0;
    end else m_ctx = 1;
  endtask

  // behavioural reference: walks the whole command list
  task automatic build_model();
    m_ctx = 0; m_rd = 8'hA0;
    foreach (cmd_q[i]) begin
      logic [7:0] b; bit st, sp;
      b = cmd_q[i][7:0]; st = cmd_q[i][8]; sp = cmd_q[i][9];
      if (m_ctx == 2) begin
        for (int k = 0; k < int'(b); k++) begin
          m_op(2, (k != int'(b) - 1) ? 1 : 0, 0, "R3");
          exp_rx.push_back(int'(m_rd)); m_rd = m_rd + 8'd1;
        end
        if (b != 0) m_ev(1, "R8");
        if (sp) begin
          m_op(3, 0, 0, (b == 0) ? "R13" : "R4"); m_ev(3, "R4"); m_ctx = 0;
        end else m_ctx = 3;
      end else if (st) begin
        m_op(0, 0, 0, (m_ctx == 0) ? "R1" : "R5");
        m_op(1, 0, int'(b), "R1");
        m_write_result(b, sp, 1'b1);
      end else if (m_ctx == 1) begin
        m_op(1, 0, int'(b), "R1");
        m_write_result(b, sp, 1'b0);
      end
    end
  endtask

  initial begin
    int cyc, quiet, pend_cnt;
    bit pend, was_pend, hold_seen;
    logic [1:0] pend_kind, h_kind;
    logic [7:0] pend_byte, h_byte, rd_seq;
    logic h_ack;
    int busy_cnt;

    rst_n = 1'b0; cmd_valid = 0; cmd_data = '0; op_ready = 0; op_done = 0;
    op_nack = 0; op_arb_lost = 0; op_rdata = '0; bus_busy = 0; rx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "reset cmd_ready", cmd_ready, 1);
    chk(op_valid == 1'b0, "R12", "reset op_valid", op_valid, 0);
    chk(rx_valid == 1'b0, "R2", "reset rx_valid", rx_valid, 0);
    chk({ev_tx_error, ev_arb_lost, ev_bus_idle} == 3'b0, "R4", "reset events",
        {ev_tx_error, ev_arb_lost, ev_bus_idle}, 0);

    // scenarios
    cmd_q = '{10'h1A0, 10'h011, 10'h022, 10'h233,   // write, stop on last
              10'h350,                              // address only
              10'h1A1, 10'h203,                     // read 3, stop
              10'h1A4, 10'h005, 10'h1A5, 10'h202,   // write then repeated-start read
              10'h1EE, 10'h201,                     // address NACK, trailing entry dropped
              10'h1B0, 10'h0C3, 10'h207,            // arbitration lost on data
              10'h077,                              // stray entry while idle
              10'h1A1, 10'h200,                     // zero-length read
              10'h1A3, 10'h001, 10'h009, 10'h3A6,   // held read, stray, repeated-start address-only
              10'h1A8, 10'h0EE, 10'h209,            // data NACK
              10'h1AB, 10'h2FF};                    // 255-byte read
    build_model();

    cyc = 0; quiet = 0; pend = 0; pend_cnt = 0; busy_cnt = 0; rd_seq = 8'hA0;
    hold_seen = 0; pend_kind = '0; pend_byte = '0; h_kind = '0; h_byte = '0; h_ack = 0;
    while (quiet < 40 && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      was_pend = pend;
      // events
      if (ev_tx_error || ev_arb_lost || ev_bus_idle) begin
        int code;
        code = ev_tx_error ? 1 : ev_arb_lost ? 2 : 3;
        if (exp_ev.size() == 0) chk(0, "R10", "unexpected event", code, 0);
        else begin
          chk(code == exp_ev[0], ev_tag[0], "event", code, exp_ev[0]);
          void'(exp_ev.pop_front()); void'(ev_tag.pop_front());
        end
      end
      // engine completion
      op_done = 0; op_nack = 0; op_arb_lost = 0;
      if (busy_cnt > 0) begin busy_cnt--; if (busy_cnt == 0) bus_busy = 0; end
      if (pend) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          pend = 0; op_done = 1;
          case (pend_kind)
            2'd0: bus_busy = 1;
            2'd1: begin
              op_nack = (pend_byte == NACK_BYTE);
              op_arb_lost = (pend_byte == ARB_BYTE);
              if (op_arb_lost) bus_busy = 0;
            end
            2'd2: begin op_rdata = rd_seq; rd_seq = rd_seq + 8'd1; end
            default: busy_cnt = 4;
          endcase
        end
      end
      // request stability while waiting
      if (hold_seen && op_valid)
        chk({op_kind, op_byte, op_ack} == {h_kind, h_byte, h_ack}, "R12",
            "op fields stable", {op_kind, op_byte, op_ack}, {h_kind, h_byte, h_ack});
      op_ready = !pend && (cyc % 2 == 0);
      hold_seen = op_valid && !op_ready;
      h_kind = op_kind; h_byte = op_byte; h_ack = op_ack;
      if (op_valid && op_ready) begin
        int got;
        got = enc(int'(op_kind), int'(op_ack), int'(op_byte));
        if (exp_ops.size() == 0) chk(0, "R10", "unexpected op", got, 0);
        else begin
          chk(got == exp_ops[0], op_tag[0], "op {kind,ack,byte}", got, exp_ops[0]);
          void'(exp_ops.pop_front()); void'(op_tag.pop_front());
        end
        pend = 1; pend_cnt = 3; pend_kind = op_kind; pend_byte = op_byte;
      end
      // receive stream
      rx_ready = (cyc % 3 != 0);
      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) chk(0, "R2", "unexpected rx byte", rx_data, 0);
        else chk(int'(rx_data) == exp_rx.pop_front(), "R2", "rx byte", rx_data, rx_data);
      end
      // fetch only while nothing outstanding
      if (was_pend) chk(cmd_ready == 1'b0, "R11", "cmd_ready while op outstanding", cmd_ready, 0);
      // command stream with gaps
      cmd_valid = (cmd_q.size() > 0) && (cyc % 5 != 0);
      cmd_data  = (cmd_q.size() > 0) ? cmd_q[0] : '0;
      if (cmd_valid && cmd_ready) void'(cmd_q.pop_front());
      if (cmd_q.size() == 0 && !pend && busy_cnt == 0 && !op_valid && !rx_valid && cmd_ready)
        quiet++;
      else quiet = 0;
    end
    cmd_valid = 0;
    if (cyc >= 150000) chk(0, "R11", "watchdog expired", cyc, 0);
    chk(exp_ops.size() == 0, "R10", "ops left over", exp_ops.size(), 0);
    chk(exp_rx.size() == 0, "R2", "rx bytes left over", exp_rx.size(), 0);
    chk(exp_ev.size() == 0, "R4", "events left over", exp_ev.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule